// File: doc/BRIEF.md
# External Interrupt Controller

This block watches a set of external interrupt pins, all sampled on one synchronous clock. Every pin first passes through a two-stage synchronizer. It may then go through a majority-of-three glitch filter. After that it is tested against a per-channel trigger condition: a rising or falling edge, or a high or low level. A trigger sets a sticky status bit for that channel.

Two independent controls act on each channel. The channel-active bit decides whether the channel is live at all; while it is off, the channel's status is held at zero. The mask bit decides only whether a live status bit reaches the interrupt output. A live but masked channel still records its status and raises the wake output, so it can wake the system without interrupting it.

Software reaches the configuration through a small register port. This port has an address, write strobe, read strobe and data bus. Writes take effect on the next clock edge. Read data appears one cycle after the read strobe. Set and clear controls are separate write-one addresses, so channels can be changed without a read-modify-write.

Top module: `ext_irq_ctrl`

## Requirements
- R1: With the filter off, a pin change driven before clock edge 1 shows on `irq_o`/`wake_o` right after edge 3, and not after edge 2.
- R2: With trigger-kind bit 0 (edge), edge-polarity bit 1 triggers on a rising edge and 0 on a falling edge. The opposite edge never triggers. A pin pulse lasting one cycle is detected.
- R3: With trigger-kind bit 1 (level), level-polarity bit 1 triggers while the pin is high and 0 while it is low.
- R4: With the filter bit set, the condition is taken from the majority of the last three synchronized samples. A steady change appears one cycle later than in R1 (after edge 4). A one-cycle pulse is rejected.
- R5: A status bit stays set until a 1 is written to its bit at the status-clear address (8). Bits written as 0 leave status unchanged.
- R6: When a trigger and a status-clear write for the same channel fall in one cycle, the status bit stays set.
- R7: Writing 1 to address 4 sets mask bits and writing 1 to address 5 clears them. `irq_o` bit = status AND mask AND active. A live, masked-off channel still sets status and raises `wake_o`.
- R8: Writing 1 to address 9 sets channel-active bits and writing 1 to address 10 clears them. A channel whose active bit is 0 keeps status 0 and gives no wake. Clearing the active bit also clears status on the same edge.
- R9: Reads return data one cycle after `bus_rd`. The readable addresses are: 0 trigger kind, 1 edge polarity, 2 level polarity, 3 filter enable, 6 mask, 7 status and 11 active. All other addresses read 0.
- R10: After reset, all registers are 0 and `irq_o` and `wake_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NUM_CH | Asynchronous external interrupt pins |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | NUM_CH | Write data, one bit per channel |
| bus_rdata | output | NUM_CH | Read data, valid one cycle after `bus_rd` |
| irq_o | output | NUM_CH | Per-channel interrupt requests |
| wake_o | output | 1 | Any live channel has status set |

## Verification
With the filter off, a pin driven before edge 1 lands in status on edge 3: two synchronizer stages plus the status flop. The filter adds one history stage, so the same change lands on edge 4. Register writes update control on the edge inside the write strobe. Status reacts to the active bit one edge after that. Read data is registered on the edge following the strobe. The bench drives every input on a falling edge and samples on falling edges. It counts whole cycles with a step task, so every check samples on the first falling edge after the due rising edge. Where the due time itself is under test, it also checks that the result is still absent one cycle earlier.

// File: rtl/eirq_pkg.sv
// Package eirq_pkg
// Shared register address map and helper functions for the external
// interrupt controller. Assumes a 4-bit register address.
package eirq_pkg;

    localparam int unsigned ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_KIND     = 4'd0,   // trigger kind: 0 edge, 1 level
        REG_EDGE_POL = 4'd1,   // 1 rising, 0 falling
        REG_LVL_POL  = 4'd2,   // 1 high, 0 low
        REG_FILT     = 4'd3,   // majority filter enable
        REG_MASK_SET = 4'd4,   // write-one-to-set mask
        REG_MASK_CLR = 4'd5,   // write-one-to-clear mask
        REG_MASK     = 4'd6,   // mask readback
        REG_STAT     = 4'd7,   // status readback
        REG_STAT_CLR = 4'd8,   // write-one-to-clear status
        REG_ACT_SET  = 4'd9,   // write-one-to-set channel active
        REG_ACT_CLR  = 4'd10,  // write-one-to-clear channel active
        REG_ACT      = 4'd11   // active readback
    } reg_sel_e;

    // Majority of three single-bit samples.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/eirq_sync.sv
// Module eirq_sync
// Multi-stage synchronizer for a vector of asynchronous pins. Each bit
// is treated independently; no bus coherency is implied. Assumes STAGES >= 2.
module eirq_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    // Capture stage: first flop of the chain samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q[0] <= '0;
        end else begin
            chain_q[0] <= async_i;
        end
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Settling stage: shift the sample one flop further.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q[g] <= '0;
                end else begin
                    chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/eirq_detect.sv
// Module eirq_detect
// Per-channel optional majority filter and trigger condition check.
// Inputs are already synchronous. The edge history runs whether or not a
// channel is active, so enabling a channel never creates a false edge.
module eirq_detect
    import eirq_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] sample_i,
    input  logic [NUM_CH-1:0] kind_i,
    input  logic [NUM_CH-1:0] edge_pol_i,
    input  logic [NUM_CH-1:0] lvl_pol_i,
    input  logic [NUM_CH-1:0] filt_en_i,
    output logic [NUM_CH-1:0] trig_o
);

    genvar ch;
    generate
        for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
            logic hist1_q;
            logic hist2_q;
            logic prev_q;
            logic value;
            logic edge_hit;
            logic lvl_hit;

            // History: keep the last two synchronized samples and the last filtered value.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hist1_q <= 1'b0;
                    hist2_q <= 1'b0;
                    prev_q  <= 1'b0;
                end else begin
                    hist1_q <= sample_i[ch];
                    hist2_q <= hist1_q;
                    prev_q  <= value;
                end
            end

            // Condition: choose raw or voted value, then test edge or level.
            always_comb begin
                value    = filt_en_i[ch] ? maj3(sample_i[ch], hist1_q, hist2_q)
                                         : sample_i[ch];
                edge_hit = edge_pol_i[ch] ? (value & ~prev_q) : (~value & prev_q);
                lvl_hit  = (value == lvl_pol_i[ch]);
                trig_o[ch] = kind_i[ch] ? lvl_hit : edge_hit;
            end
        end
    endgenerate

endmodule

// File: rtl/eirq_regs.sv
// Module eirq_regs
// Register file: configuration, mask, channel-active and sticky status,
// plus a registered read port. If set and clear hit the same bit in one
// cycle, the clear wins for mask and active. A trigger beats a status
// clear. Deactivating a channel zeroes its status.
module eirq_regs
    import eirq_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [NUM_CH-1:0] bus_wdata,
    output logic [NUM_CH-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] trig_i,
    output logic [NUM_CH-1:0] kind_o,
    output logic [NUM_CH-1:0] edge_pol_o,
    output logic [NUM_CH-1:0] lvl_pol_o,
    output logic [NUM_CH-1:0] filt_en_o,
    output logic [NUM_CH-1:0] mask_o,
    output logic [NUM_CH-1:0] act_o,
    output logic [NUM_CH-1:0] stat_o
);

    logic [NUM_CH-1:0] kind_q, edge_pol_q, lvl_pol_q, filt_q;
    logic [NUM_CH-1:0] mask_q, act_q, stat_q;
    logic [NUM_CH-1:0] mask_set, mask_clr, act_set, act_clr, stat_clr;
    logic [NUM_CH-1:0] mask_d, act_d, stat_d, rd_mux;

    // Write decode: turn address and strobe into per-channel set/clear vectors.
    always_comb begin
        mask_set = (bus_wr && bus_addr == REG_MASK_SET) ? bus_wdata : '0;
        mask_clr = (bus_wr && bus_addr == REG_MASK_CLR) ? bus_wdata : '0;
        act_set  = (bus_wr && bus_addr == REG_ACT_SET)  ? bus_wdata : '0;
        act_clr  = (bus_wr && bus_addr == REG_ACT_CLR)  ? bus_wdata : '0;
        stat_clr = (bus_wr && bus_addr == REG_STAT_CLR) ? bus_wdata : '0;
    end

    // Next state: clear beats set for controls; trigger beats clear for status.
    always_comb begin
        mask_d = (mask_q | mask_set) & ~mask_clr;
        act_d  = (act_q | act_set) & ~act_clr;
        stat_d = act_q & ~act_clr & (trig_i | (stat_q & ~stat_clr));
    end

    // Configuration registers: plain read/write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q     <= '0;
            edge_pol_q <= '0;
            lvl_pol_q  <= '0;
            filt_q     <= '0;
        end else if (bus_wr) begin
            if (bus_addr == REG_KIND)     kind_q     <= bus_wdata;
            if (bus_addr == REG_EDGE_POL) edge_pol_q <= bus_wdata;
            if (bus_addr == REG_LVL_POL)  lvl_pol_q  <= bus_wdata;
            if (bus_addr == REG_FILT)     filt_q     <= bus_wdata;
        end
    end

    // Control and status state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            act_q  <= '0;
            stat_q <= '0;
        end else begin
            mask_q <= mask_d;
            act_q  <= act_d;
            stat_q <= stat_d;
        end
    end

    // Read select: readable addresses return state, all others zero.
    always_comb begin
        case (bus_addr)
            REG_KIND:     rd_mux = kind_q;
            REG_EDGE_POL: rd_mux = edge_pol_q;
            REG_LVL_POL:  rd_mux = lvl_pol_q;
            REG_FILT:     rd_mux = filt_q;
            REG_MASK:     rd_mux = mask_q;
            REG_STAT:     rd_mux = stat_q;
            REG_ACT:      rd_mux = act_q;
            default:      rd_mux = '0;
        endcase
    end

    // Read data register: one-cycle read latency, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    assign kind_o     = kind_q;
    assign edge_pol_o = edge_pol_q;
    assign lvl_pol_o  = lvl_pol_q;
    assign filt_en_o  = filt_q;
    assign mask_o     = mask_q;
    assign act_o      = act_q;
    assign stat_o     = stat_q;

endmodule

// File: rtl/ext_irq_ctrl.sv
// Module ext_irq_ctrl
// Top of the external interrupt controller: synchronizer, filter and
// detector, and register file. Produces per-channel requests and a wake
// flag. Assumes all pins and the bus sit in the clk domain, except
// pin_i, which is asynchronous.
module ext_irq_ctrl
    import eirq_pkg::*;
#(
    parameter int unsigned NUM_CH      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pin_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [NUM_CH-1:0] bus_wdata,
    output logic [NUM_CH-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq_o,
    output logic              wake_o
);

    logic [NUM_CH-1:0] pin_sync;
    logic [NUM_CH-1:0] trig;
    logic [NUM_CH-1:0] kind, edge_pol, lvl_pol, filt_en;
    logic [NUM_CH-1:0] mask_q, act_q, stat_q;

    eirq_sync #(
        .WIDTH  (NUM_CH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    eirq_detect #(
        .NUM_CH (NUM_CH)
    ) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_i   (pin_sync),
        .kind_i     (kind),
        .edge_pol_i (edge_pol),
        .lvl_pol_i  (lvl_pol),
        .filt_en_i  (filt_en),
        .trig_o     (trig)
    );

    eirq_regs #(
        .NUM_CH (NUM_CH)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .trig_i     (trig),
        .kind_o     (kind),
        .edge_pol_o (edge_pol),
        .lvl_pol_o  (lvl_pol),
        .filt_en_o  (filt_en),
        .mask_o     (mask_q),
        .act_o      (act_q),
        .stat_o     (stat_q)
    );

    // Output stage: request needs status, mask and active; wake ignores the mask.
    always_comb begin
        irq_o  = stat_q & mask_q & act_q;
        wake_o = |(stat_q & act_q);
    end

endmodule

// File: rtl/eirq_checker.sv
// Module eirq_checker
// Property checker bound to ext_irq_ctrl. Observes ports and the
// mask/active/status state; drives nothing.
module eirq_checker
    import eirq_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [NUM_CH-1:0] bus_wdata,
    input logic [NUM_CH-1:0] bus_rdata,
    input logic [NUM_CH-1:0] irq_o,
    input logic              wake_o,
    input logic [NUM_CH-1:0] mask_q,
    input logic [NUM_CH-1:0] act_q,
    input logic [NUM_CH-1:0] stat_q
);

    AST_STAT_NEEDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & ~act_q) == '0); // R8

    AST_ACT_CLR_DROPS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_ACT_CLR) |=> ((stat_q & $past(bus_wdata)) == '0)); // R8

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == REG_STAT_CLR || bus_addr == REG_ACT_CLR))
        |=> (($past(stat_q) & ~stat_q) == '0)); // R5

    AST_IRQ_IMPLIES_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) |-> wake_o); // R7

    AST_MASK_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_MASK_SET)
        |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata))); // R7

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == REG_STAT) |=> (bus_rdata == $past(stat_q))); // R9

endmodule

bind ext_irq_ctrl eirq_checker #(
    .NUM_CH (NUM_CH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .wake_o    (wake_o),
    .mask_q    (mask_q),
    .act_q     (act_q),
    .stat_q    (stat_q)
);

// File: tb/ext_irq_ctrl_tb.sv
`timescale 1ns/1ps
// Directed bench for ext_irq_ctrl: one task per scenario, each checking itself.
module ext_irq_ctrl_tb;

    localparam int unsigned NUM_CH = 8;
    localparam logic [3:0] A_KIND = 4'd0, A_EPOL = 4'd1, A_LPOL = 4'd2, A_FILT = 4'd3;
    localparam logic [3:0] A_MSET = 4'd4, A_MCLR = 4'd5, A_MASK = 4'd6, A_STAT = 4'd7;
    localparam logic [3:0] A_SCLR = 4'd8, A_ASET = 4'd9, A_ACLR = 4'd10, A_ACT = 4'd11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] pins = '0;
    logic [3:0]        addr = '0;
    logic              wr = 1'b0;
    logic              rd = 1'b0;
    logic [NUM_CH-1:0] wdata = '0;
    logic [NUM_CH-1:0] rdata;
    logic [NUM_CH-1:0] irq;
    logic              wake;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ext_irq_ctrl #(.NUM_CH(NUM_CH)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pins),
        .bus_addr  (addr),
        .bus_wr    (wr),
        .bus_rd    (rd),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_o     (irq),
        .wake_o    (wake)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [NUM_CH-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [NUM_CH-1:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pins = '0; wr = 1'b0; rd = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    // R10: everything cleared after reset.
    task automatic t_reset();
        logic [NUM_CH-1:0] v;
        do_reset();
        chk("R10 irq", irq, 0);
        chk("R10 wake", wake, 0);
        bus_read(A_MASK, v); chk("R10 mask", v, 0);
        bus_read(A_STAT, v); chk("R10 status", v, 0);
        bus_read(A_ACT, v);  chk("R10 active", v, 0);
        bus_read(A_KIND, v); chk("R10 kind", v, 0);
    endtask

    // R1, R2: edge polarity and synchronizer latency.
    task automatic t_edge();
        do_reset();
        bus_write(A_EPOL, 8'h01);
        bus_write(A_MSET, 8'h03);
        bus_write(A_ASET, 8'h03);
        pins[1] = 1'b1; step(5);
        chk("R2 rising ignored on falling channel", wake, 0);
        pins[0] = 1'b1; step(2);
        chk("R1 not yet after edge 2", irq, 0);
        step(1);
        chk("R1 irq after edge 3", irq, 8'h01);
        chk("R1 wake after edge 3", wake, 1);
        bus_write(A_SCLR, 8'h01);
        pins[0] = 1'b0; step(5);
        chk("R2 falling ignored on rising channel", irq, 0);
        pins[1] = 1'b0; step(3);
        chk("R2 falling edge triggers", irq, 8'h02);
        bus_write(A_SCLR, 8'h02);
        pins[0] = 1'b1; step(1); pins[0] = 1'b0; step(5);
        chk("R2 one-cycle pulse detected", irq, 8'h01);
    endtask

    // R3: level polarity.
    task automatic t_level();
        do_reset();
        bus_write(A_KIND, 8'h0C);
        bus_write(A_LPOL, 8'h04);
        pins[3] = 1'b1; step(3);
        bus_write(A_MSET, 8'h0C);
        bus_write(A_ASET, 8'h0C);
        step(3);
        chk("R3 no level hit", wake, 0);
        pins[2] = 1'b1; step(3);
        chk("R3 high level", irq, 8'h04);
        pins[3] = 1'b0; step(3);
        chk("R3 low level", irq, 8'h0C);
    endtask

    // R4: majority filter.
    task automatic t_filter();
        do_reset();
        bus_write(A_KIND, 8'h10);
        bus_write(A_LPOL, 8'h10);
        bus_write(A_FILT, 8'h10);
        bus_write(A_MSET, 8'h10);
        bus_write(A_ASET, 8'h10);
        pins[4] = 1'b1; step(1); pins[4] = 1'b0; step(6);
        chk("R4 pulse rejected", irq, 0);
        pins[4] = 1'b1; step(3);
        chk("R4 not yet after edge 3", irq, 0);
        step(1);
        chk("R4 irq after edge 4", irq, 8'h10);
    endtask

    // R5, R6: sticky status and trigger-over-clear.
    task automatic t_clear();
        logic [NUM_CH-1:0] v;
        do_reset();
        bus_write(A_KIND, 8'h40);
        bus_write(A_EPOL, 8'h20);
        bus_write(A_LPOL, 8'h40);
        bus_write(A_MSET, 8'h60);
        bus_write(A_ASET, 8'h60);
        pins[5] = 1'b1; step(4);
        chk("R5 edge status set", irq, 8'h20);
        bus_write(A_SCLR, 8'hDF);
        chk("R5 zero bits leave status", irq, 8'h20);
        step(3);
        chk("R5 status sticky", irq, 8'h20);
        bus_write(A_SCLR, 8'h20);
        chk("R5 clear removes status", irq, 0);
        pins[6] = 1'b1; step(3);
        bus_write(A_SCLR, 8'h40);
        chk("R6 trigger beats clear", irq, 8'h40);
        bus_read(A_STAT, v);
        chk("R6 status readback", v, 8'h40);
    endtask

    // R7: mask is independent of status and wake.
    task automatic t_mask();
        logic [NUM_CH-1:0] v;
        do_reset();
        bus_write(A_EPOL, 8'h80);
        bus_write(A_ASET, 8'h80);
        pins[7] = 1'b1; step(4);
        chk("R7 masked: wake", wake, 1);
        chk("R7 masked: no irq", irq, 0);
        bus_write(A_MSET, 8'h80);
        chk("R7 unmask raises irq", irq, 8'h80);
        bus_read(A_MASK, v); chk("R7 mask readback", v, 8'h80);
        bus_write(A_MCLR, 8'h80);
        chk("R7 mask clear drops irq", irq, 0);
        chk("R7 wake kept", wake, 1);
        bus_read(A_STAT, v); chk("R7 status kept", v, 8'h80);
    endtask

    // R8: channel active control.
    task automatic t_enable();
        logic [NUM_CH-1:0] v;
        do_reset();
        bus_write(A_KIND, 8'h01);
        bus_write(A_LPOL, 8'h01);
        bus_write(A_MSET, 8'h01);
        pins[0] = 1'b1; step(4);
        chk("R8 inactive: no wake", wake, 0);
        bus_read(A_STAT, v); chk("R8 inactive: status zero", v, 0);
        bus_write(A_ASET, 8'h01);
        step(1);
        chk("R8 active: irq", irq, 8'h01);
        bus_read(A_ACT, v); chk("R8 active readback", v, 8'h01);
        bus_write(A_ACLR, 8'h01);
        chk("R8 deactivate clears irq", irq, 0);
        chk("R8 deactivate clears wake", wake, 0);
        bus_read(A_STAT, v); chk("R8 status zero while inactive", v, 0);
    endtask

    // R9: register readback and unmapped addresses.
    task automatic t_readback();
        logic [NUM_CH-1:0] v;
        do_reset();
        bus_write(A_KIND, 8'hFF);
        bus_write(A_EPOL, 8'hA5);
        bus_write(A_LPOL, 8'h3C);
        bus_write(A_FILT, 8'h5A);
        bus_read(A_KIND, v); chk("R9 kind", v, 8'hFF);
        bus_read(A_EPOL, v); chk("R9 edge polarity", v, 8'hA5);
        bus_read(A_LPOL, v); chk("R9 level polarity", v, 8'h3C);
        bus_read(A_FILT, v); chk("R9 filter", v, 8'h5A);
        bus_read(A_MSET, v); chk("R9 write-only reads 0", v, 0);
        bus_read(4'd14, v);  chk("R9 unmapped reads 0", v, 0);
    endtask

    initial begin
        t_reset();
        t_edge();
        t_level();
        t_filter();
        t_clear();
        t_mask();
        t_enable();
        t_readback();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule